// File: doc/BRIEF.md
# Double-Buffered PCM Playback Engine

This block plays 16-bit stereo PCM from system memory to a serial DAC. Software describes each buffer with a start address and a byte length. The address is written first. The length write then commits the pair as a descriptor. The engine holds two descriptors: the one being fetched (active) and one waiting behind it (pending). Software can therefore queue the next buffer while the current one drains.

The engine reads one 32-bit word per stereo frame over a simple request/valid read bus. It keeps that word in a one-frame holding register. At every sample tick it moves the word into a shifter that drives a bit clock, a channel-select line and a data line. The tick period and the bit-clock rate are programmable dividers of the block clock.

An interrupt is raised when a pending descriptor moves into the active slot. It therefore arrives one buffer behind the most recently queued buffer. Software clears it by writing the status register.

Top module: `pcm_dma_out`

## Requirements
- R1: Register select 0 stages a start address (its bits 1:0 are forced to zero). Register select 1 commits a descriptor made of the staged address and a frame count equal to the written byte length shifted right by 2. A commit whose frame count is zero is ignored.
- R2: A commit with the active slot empty loads the active slot at once. A commit with only the active slot occupied fills the pending slot. Status (select 3) bit 31 reads 1 while both slots are occupied, and bit 30 reads 1 while the active slot holds frames not yet fetched.
- R3: A commit while both slots are occupied is ignored, and bit 31 stays 1.
- R4: Status bit 0 (interrupt, also driven on `irq`) is set when the active descriptor fetches its last frame and a pending descriptor is promoted. A commit into an empty active slot does not set it, so the interrupt arrives before any frame of the promoted buffer is played.
- R5: A write of any value to select 3 clears the interrupt. A promotion in the same cycle wins.
- R6: Control (select 2) bit 0 enables fetching. While it is 0, no new memory request is issued, and queued descriptors are kept.
- R7: Frames are fetched in order from the start address in steps of 4. Each request holds `mem_req` high with a stable `mem_addr` until `mem_rvalid` is seen.
- R8: A fetched word carries the left sample in bits 31:16 (the lowest byte address holds its high byte) and the right sample in bits 15:0. The 32 bits are sent MSB first. `dac_lrck` is 0 during the 16 left bits and 1 during the 16 right bits.
- R9: A new frame starts every RATE+1 clock cycles, where RATE is the value in select 4.
- R10: Select 5 holds D-1. `dac_bclk` stays low for D cycles and high for D cycles per bit, data changes on its falling edge, and after 32 bits the clock rests low with `dac_lrck` high. RATE+1 must be at least 64·D.
- R11: A frame that starts with no fetched word waiting sends all zeros. When the active buffer ends with nothing pending, busy clears and only zero frames follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the sample-rate reference |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 24 | Byte address of the requested frame |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data word (one stereo frame) |
| irq | output | 1 | Buffer-promotion interrupt |
| dac_bclk | output | 1 | Serial bit clock |
| dac_lrck | output | 1 | Channel select, 0 = left |
| dac_sdata | output | 1 | Serial sample data, MSB first |

## Verification
The bench sweeps four divider settings (D of 1, 2 and 3, with several RATE values). Each setting gets a different pair of buffer lengths, and some lengths carry stray low bits. The captured serial stream must match the fetched words in order. This separates a wrong fetch order or address step from a wrong bit order or channel split, and the measured frame and bit-clock periods separate the two dividers from each other. Each setting also queues a third buffer while both slots are full and watches for the interrupt before the second buffer is heard. This is what distinguishes the one-behind interrupt and the ignored commit from an engine that raises the interrupt on every load or that overwrites the pending slot.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;

    localparam int ADDR_W  = 24;
    localparam int LEN_W   = 18;
    localparam int FRM_W   = LEN_W - 2;
    localparam int RATE_W  = 14;
    localparam int BDIV_W  = 4;
    localparam int FRAME_W = 32;
    localparam int BIT_IDX_W = $clog2(FRAME_W);

    localparam int STAT_FULL_BIT = 31;
    localparam int STAT_BUSY_BIT = 30;
    localparam int STAT_IRQ_BIT  = 0;

    typedef enum logic [2:0] {
        SEL_ADDR = 3'd0,
        SEL_LEN  = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_STAT = 3'd3,
        SEL_RATE = 3'd4,
        SEL_BDIV = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [FRM_W-1:0]  frames;
    } desc_t;

    function automatic logic [FRM_W-1:0] bytes_to_frames(input logic [LEN_W-1:0] len);
        return len[LEN_W-1:2];
    endfunction

    function automatic logic [ADDR_W-1:0] next_frame_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(FRAME_W / 8);
    endfunction

endpackage

// File: rtl/pcm_dma_regs.sv
module pcm_dma_regs
    import pcm_dma_pkg::*;
#(
    parameter logic [RATE_W-1:0] RATE_RST = RATE_W'(63),
    parameter logic [BDIV_W-1:0] BDIV_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              q_full,
    input  logic              q_busy,
    input  logic              irq_pend,
    output logic              commit,
    output desc_t             commit_desc,
    output logic              irq_ack,
    output logic              fetch_en,
    output logic [RATE_W-1:0] rate_div,
    output logic [BDIV_W-1:0] bdiv
);

    reg_sel_e          sel;
    logic [ADDR_W-1:0] staged_addr;
    logic [FRM_W-1:0]  wr_frames;
    logic [31-ADDR_W:0] unused_wdata_hi;

    assign sel             = reg_sel_e'(reg_sel);
    assign unused_wdata_hi = reg_wdata[31:ADDR_W];
    assign wr_frames       = bytes_to_frames(reg_wdata[LEN_W-1:0]);

    assign commit             = reg_we && (sel == SEL_LEN) && (wr_frames != '0);
    assign commit_desc.addr   = staged_addr;
    assign commit_desc.frames = wr_frames;
    assign irq_ack            = reg_we && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_addr <= '0;
            fetch_en    <= 1'b0;
            rate_div    <= RATE_RST;
            bdiv        <= BDIV_RST;
        end else if (reg_we) begin
            case (sel)
                SEL_ADDR: staged_addr <= {reg_wdata[ADDR_W-1:2], 2'b00};
                SEL_CTRL: fetch_en    <= reg_wdata[0];
                SEL_RATE: rate_div    <= reg_wdata[RATE_W-1:0];
                SEL_BDIV: bdiv        <= reg_wdata[BDIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_ADDR: reg_rdata[ADDR_W-1:0] = staged_addr;
            SEL_CTRL: reg_rdata[0]          = fetch_en;
            SEL_STAT: begin
                reg_rdata[STAT_FULL_BIT] = q_full;
                reg_rdata[STAT_BUSY_BIT] = q_busy;
                reg_rdata[STAT_IRQ_BIT]  = irq_pend;
            end
            SEL_RATE: reg_rdata[RATE_W-1:0] = rate_div;
            SEL_BDIV: reg_rdata[BDIV_W-1:0] = bdiv;
            default: ;
        endcase
    end

    // R5
    ack_reaches_queue_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 3'd3) |-> irq_ack);

endmodule

// File: rtl/pcm_desc_queue.sv
module pcm_desc_queue
    import pcm_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  desc_t             commit_desc,
    input  logic              fetch_done,
    input  logic              irq_ack,
    output logic              act_valid,
    output logic [ADDR_W-1:0] act_addr,
    output logic              full,
    output logic              busy,
    output logic              irq
);

    desc_t act_q, pend_q, act_n, pend_n;
    logic  act_v_q, pend_v_q, act_v_n, pend_v_n;
    logic  retire, accept, promote;

    assign retire = fetch_done && act_v_q && (act_q.frames == FRM_W'(1));
    assign accept = commit && !(act_v_q && pend_v_q);

    always_comb begin
        act_n    = act_q;
        pend_n   = pend_q;
        act_v_n  = act_v_q;
        pend_v_n = pend_v_q;
        promote  = 1'b0;
        if (fetch_done && act_v_q) begin
            act_n.addr   = next_frame_addr(act_q.addr);
            act_n.frames = act_q.frames - FRM_W'(1);
        end
        if (retire) begin
            if (pend_v_q) begin
                act_n    = pend_q;
                act_v_n  = 1'b1;
                pend_v_n = 1'b0;
                promote  = 1'b1;
            end else begin
                act_v_n = 1'b0;
            end
        end
        if (accept) begin
            if (!act_v_n) begin
                act_n   = commit_desc;
                act_v_n = 1'b1;
            end else begin
                pend_n   = commit_desc;
                pend_v_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            pend_q   <= '0;
            act_v_q  <= 1'b0;
            pend_v_q <= 1'b0;
            irq      <= 1'b0;
        end else begin
            act_q    <= act_n;
            pend_q   <= pend_n;
            act_v_q  <= act_v_n;
            pend_v_q <= pend_v_n;
            if (promote)
                irq <= 1'b1;
            else if (irq_ack)
                irq <= 1'b0;
        end
    end

    assign act_valid = act_v_q;
    assign act_addr  = act_q.addr;
    assign full      = act_v_q && pend_v_q;
    assign busy      = act_v_q;

    // R3
    full_commit_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && full && !fetch_done) |=> (full && $stable(pend_q.addr) && $stable(pend_q.frames)));

    // R4
    irq_on_promotion_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(pend_v_q && fetch_done));

endmodule

// File: rtl/pcm_fetch.sv
module pcm_fetch
    import pcm_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_en,
    input  logic               act_valid,
    input  logic [ADDR_W-1:0]  act_addr,
    input  logic               take,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [FRAME_W-1:0] mem_rdata,
    output logic               fetch_done,
    output logic               pf_valid,
    output logic [FRAME_W-1:0] pf_data
);

    assign fetch_done = mem_req && mem_rvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            pf_valid <= 1'b0;
            pf_data  <= '0;
        end else begin
            if (mem_req) begin
                if (mem_rvalid)
                    mem_req <= 1'b0;
            end else if (fetch_en && act_valid && !pf_valid) begin
                mem_req  <= 1'b1;
                mem_addr <= act_addr;
            end
            if (fetch_done) begin
                pf_valid <= 1'b1;
                pf_data  <= mem_rdata;
            end else if (take) begin
                pf_valid <= 1'b0;
            end
        end
    end

    // R7
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R6
    no_req_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_en && !mem_req) |=> !mem_req);

endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer
    import pcm_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATE_W-1:0]  rate_div,
    input  logic [BDIV_W-1:0]  bdiv,
    input  logic               pf_valid,
    input  logic [FRAME_W-1:0] pf_data,
    output logic               tick,
    output logic               dac_bclk,
    output logic               dac_lrck,
    output logic               dac_sdata
);

    logic [RATE_W-1:0]    rate_cnt;
    logic [BDIV_W-1:0]    bclk_cnt;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [FRAME_W-1:0]   shreg;
    logic                 running;

    assign tick = (rate_cnt >= rate_div);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_cnt <= '0;
            bclk_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            running  <= 1'b0;
            dac_bclk <= 1'b0;
        end else begin
            rate_cnt <= tick ? '0 : rate_cnt + RATE_W'(1);
            if (tick) begin
                shreg    <= pf_valid ? pf_data : '0;
                bit_idx  <= '0;
                bclk_cnt <= '0;
                dac_bclk <= 1'b0;
                running  <= 1'b1;
            end else if (running) begin
                if (bclk_cnt >= bdiv) begin
                    bclk_cnt <= '0;
                    dac_bclk <= ~dac_bclk;
                    if (dac_bclk) begin
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        if (bit_idx == BIT_IDX_W'(FRAME_W - 1))
                            running <= 1'b0;
                        else
                            bit_idx <= bit_idx + BIT_IDX_W'(1);
                    end
                end else begin
                    bclk_cnt <= bclk_cnt + BDIV_W'(1);
                end
            end
        end
    end

    assign dac_lrck  = running ? bit_idx[BIT_IDX_W-1] : 1'b1;
    assign dac_sdata = shreg[FRAME_W-1];

    // R11
    underrun_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !pf_valid) |=> (dac_sdata == 1'b0));

    // R8
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pf_valid) |=> (dac_sdata == $past(pf_data[FRAME_W-1])));

    // R10
    frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!dac_bclk && !dac_lrck));

endmodule

// File: rtl/pcm_dma_out.sv
module pcm_dma_out
    import pcm_dma_pkg::*;
#(
    parameter logic [RATE_W-1:0] RATE_RST = RATE_W'(63),
    parameter logic [BDIV_W-1:0] BDIV_RST = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [2:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [FRAME_W-1:0] mem_rdata,
    output logic               irq,
    output logic               dac_bclk,
    output logic               dac_lrck,
    output logic               dac_sdata
);

    desc_t              commit_desc;
    logic               commit, irq_ack, fetch_en;
    logic [RATE_W-1:0]  rate_div;
    logic [BDIV_W-1:0]  bdiv;
    logic               act_valid, q_full, q_busy;
    logic [ADDR_W-1:0]  act_addr;
    logic               fetch_done, pf_valid, tick;
    logic [FRAME_W-1:0] pf_data;

    pcm_dma_regs #(.RATE_RST(RATE_RST), .BDIV_RST(BDIV_RST)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .q_full(q_full), .q_busy(q_busy), .irq_pend(irq),
        .commit(commit), .commit_desc(commit_desc), .irq_ack(irq_ack),
        .fetch_en(fetch_en), .rate_div(rate_div), .bdiv(bdiv)
    );

    pcm_desc_queue u_queue (
        .clk(clk), .rst(rst), .commit(commit), .commit_desc(commit_desc),
        .fetch_done(fetch_done), .irq_ack(irq_ack),
        .act_valid(act_valid), .act_addr(act_addr),
        .full(q_full), .busy(q_busy), .irq(irq)
    );

    pcm_fetch u_fetch (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .act_valid(act_valid),
        .act_addr(act_addr), .take(tick), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fetch_done(fetch_done),
        .pf_valid(pf_valid), .pf_data(pf_data)
    );

    pcm_serializer u_ser (
        .clk(clk), .rst(rst), .rate_div(rate_div), .bdiv(bdiv),
        .pf_valid(pf_valid), .pf_data(pf_data), .tick(tick),
        .dac_bclk(dac_bclk), .dac_lrck(dac_lrck), .dac_sdata(dac_sdata)
    );

endmodule

// File: tb/pcm_dma_out_test.sv
`timescale 1ns/1ps
module pcm_dma_out_test;
    import pcm_dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq, dac_bclk, dac_lrck, dac_sdata;

    always #2 clk = ~clk;

    pcm_dma_out uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .irq(irq), .dac_bclk(dac_bclk), .dac_lrck(dac_lrck), .dac_sdata(dac_sdata)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    function automatic logic [31:0] frame_at(input logic [23:0] a);
        return {1'b1, a[16:2], a[9:2] ^ 8'h5A, 8'hC3};
    endfunction

    // memory model: one-cycle response
    logic [23:0] reqlog [0:63];
    int          req_n = 0;
    always @(negedge clk) begin
        if (mem_req && !mem_rvalid) begin
            mem_rvalid = 1'b1;
            mem_rdata  = frame_at(mem_addr);
            if (req_n < 64) reqlog[req_n] = mem_addr;
            req_n++;
        end else begin
            mem_rvalid = 1'b0;
        end
    end

    // serial monitor
    int          cyc = 0, last_start = 0, rise_at = 0, bitn = 0;
    int          cur_rate = 63, cur_bd = 0;
    bit          mon_chk = 1'b0, have_prev = 1'b0;
    logic        prev_bclk = 1'b0, prev_lr = 1'b1;
    logic [31:0] word = '0;
    logic [31:0] rx [0:63];
    int          rx_n = 0, zero_n = 0;
    always @(negedge clk) begin
        cyc++;
        if (prev_lr && !dac_lrck) begin
            if (mon_chk && have_prev)
                chk(cyc - last_start == cur_rate + 1, "R9 frame period", cyc - last_start, cur_rate + 1);
            have_prev  = mon_chk;
            last_start = cyc;
            bitn = 0;
            word = '0;
        end
        if (!prev_bclk && dac_bclk) begin
            rise_at = cyc;
            if (mon_chk)
                chk(dac_lrck == (bitn >= 16), "R8 channel select", dac_lrck, bitn >= 16);
            word = {word[30:0], dac_sdata};
            bitn++;
            if (bitn == 32) begin
                if (word == 0) zero_n++;
                else begin
                    if (rx_n < 64) rx[rx_n] = word;
                    rx_n++;
                end
            end
        end
        if (prev_bclk && !dac_bclk && mon_chk)
            chk(cyc - rise_at == cur_bd + 1, "R10 bclk high time", cyc - rise_at, cur_bd + 1);
        prev_bclk = dac_bclk;
        prev_lr   = dac_lrck;
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_stat(output logic [31:0] s);
        reg_sel = 3'd3;
        #0.5;
        s = reg_rdata;
    endtask

    task automatic run_case(input int rate, input int bd, input int na, input int nb, input logic [23:0] base);
        logic [31:0] s;
        logic [23:0] ba, bb, bc;
        int          guard, nexp;
        ba = base; bb = base + 24'h100; bc = base + 24'h200;
        mon_chk = 1'b0;
        wr(3'd2, 32'd0);
        wr(3'd4, rate);
        wr(3'd5, bd);
        cur_rate = rate; cur_bd = bd;
        repeat (3 * (rate + 1)) @(negedge clk);
        mon_chk = 1'b1;
        rx_n = 0; zero_n = 0; req_n = 0;
        // R1 R2: first buffer goes straight to the active slot (length with stray low bits)
        wr(3'd0, ba);
        wr(3'd1, na * 4 + 3);
        rd_stat(s);
        chk(s[30] == 1'b1, "R2 busy after first commit", s[30], 1);
        chk(s[31] == 1'b0, "R2 not full with one slot", s[31], 0);
        chk(s[0] == 1'b0, "R4 no irq on direct load", s[0], 0);
        repeat (10) @(negedge clk);
        chk(mem_req == 1'b0 && req_n == 0, "R6 no fetch while disabled", req_n, 0);
        wr(3'd0, bb);
        wr(3'd1, nb * 4 + 2);
        rd_stat(s);
        chk(s[31] == 1'b1, "R2 full with two slots", s[31], 1);
        // R3: third commit is ignored
        wr(3'd0, bc);
        wr(3'd1, 32'd16);
        rd_stat(s);
        chk(s[31] == 1'b1, "R3 full stays after ignored commit", s[31], 1);
        chk(irq == 1'b0, "R4 irq idle before promotion", irq, 0);
        wr(3'd2, 32'd1);
        guard = 0;
        while (!irq && guard < 20000) begin @(negedge clk); guard++; end
        chk(irq == 1'b1, "R4 irq on promotion", irq, 1);
        chk(rx_n < na, "R4 irq before second buffer heard", rx_n, na - 1);
        rd_stat(s);
        chk(s[31] == 1'b0 && s[30] == 1'b1, "R3 ignored buffer not queued", s[31:30], 2'b01);
        wr(3'd3, 32'hDEAD_0001);
        chk(irq == 1'b0, "R5 status write clears irq", irq, 0);
        repeat ((na + nb + 4) * (rate + 1)) @(negedge clk);
        nexp = na + nb;
        chk(rx_n == nexp, "R7 frame count played", rx_n, nexp);
        chk(req_n == nexp, "R7 request count", req_n, nexp);
        for (int i = 0; i < nexp && i < rx_n && i < 64; i++) begin
            logic [23:0] a;
            a = (i < na) ? ba + 24'(4 * i) : bb + 24'(4 * (i - na));
            chk(reqlog[i] == a, "R7 fetch address order", reqlog[i], a);
            chk(rx[i] == frame_at(a), "R8 serial frame content", rx[i], frame_at(a));
        end
        rd_stat(s);
        chk(s[30] == 1'b0, "R11 busy clears at end", s[30], 0);
        chk(zero_n > 0, "R11 zero frames after end", zero_n, 1);
        chk(irq == 1'b0, "R4 no irq when last buffer ends", irq, 0);
    endtask

    initial begin
        logic [31:0] s;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        rd_stat(s);
        chk(s == 32'd0, "R2 reset status", s, 0);
        chk(mem_req == 1'b0 && irq == 1'b0, "R6 reset outputs idle", {mem_req, irq}, 0);
        chk(dac_lrck == 1'b1 && dac_bclk == 1'b0, "R10 reset line state", {dac_lrck, dac_bclk}, 2'b10);
        // R1: zero-frame length is ignored
        wr(3'd0, 32'h0000_4000);
        wr(3'd1, 32'd3);
        rd_stat(s);
        chk(s[30] == 1'b0, "R1 zero-frame commit ignored", s[30], 0);
        wr(3'd0, 32'h0000_4007);
        reg_sel = 3'd0; #0.5;
        chk(reg_rdata == 32'h0000_4004, "R1 address low bits dropped", reg_rdata, 32'h4004);
        run_case(63, 0, 3, 2, 24'h001000);
        run_case(80, 0, 4, 1, 24'h002000);
        run_case(129, 1, 2, 3, 24'h003000);
        run_case(200, 2, 1, 2, 24'h004000);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run did not complete");
        finish_run();
    end

endmodule